// File: doc/BRIEF.md
# IPI Destination Acceptance Filter

This block sits on the receive side of a local interrupt controller. For every inter-processor interrupt message seen on the interconnect, it decides whether the local controller is one of the message's targets. A message carries a two-bit destination shorthand, a destination-mode bit (physical or logical), an 8-bit destination field and the sender's identifier. The block compares these against the controller's own physical ID and two locally held registers: a logical ID register and a format register.

The accept decision is combinational in the message inputs. It is registered once, so the accept flag is a single-cycle pulse one clock after the message strobe. A second flag tells the downstream logic whether the match came from a broadcast. That covers the two shorthand broadcasts and the all-ones physical destination. The two local registers are loaded through a byte-wide write port. The byte is the most significant byte of the addressed register.

Lowest-priority arbitration, queuing and vector delivery are handled elsewhere.

Top module: `ipi_dest_filter`

## Requirements
- R1: After reset, `acc_valid` and `acc_bcast` are 0, the stored logical ID is 00h and the format model is flat. As a result, a logical message to FFh is refused until a logical ID is written.
- R2: `acc_valid` and `acc_bcast` are registered. They reflect the message presented with `msg_valid`=1 in the previous cycle and last one cycle. A cycle with `msg_valid`=0 gives 0 on both in the following cycle.
- R3: With shorthand 01 (self), the message is accepted only when `msg_src_id` equals `local_id`, and `acc_bcast` is 0.
- R4: With shorthand 10 (all including self), the message is always accepted with `acc_bcast`=1.
- R5: With shorthand 11 (all excluding self), the message is accepted with `acc_bcast`=1 when `msg_src_id` differs from `local_id`, and refused when the two are equal.
- R6: With any shorthand other than 00, `msg_dest` and `msg_logical` have no effect on the outcome.
- R7: With shorthand 00 and `msg_logical`=0, a destination from 00h to FEh is accepted exactly when it equals `local_id`, with `acc_bcast`=0.
- R8: With shorthand 00 and `msg_logical`=0, destination FFh is accepted by every controller with `acc_bcast`=1.
- R9: In the flat model with `msg_logical`=1, the message is accepted when the bitwise AND of `msg_dest` and the logical ID is nonzero, with `acc_bcast`=0.
- R10: In the cluster model with `msg_logical`=1, the upper nibble of `msg_dest` must equal the upper nibble of the logical ID, or be Fh. In addition, the lower nibble of `msg_dest` must share a set bit with the lower nibble of the logical ID.
- R11: With shorthand 00 and `msg_logical`=1, destination 00h is refused in both models.
- R12: A write with `cfg_sel`=0 loads the logical ID from `cfg_wdata`. A write with `cfg_sel`=1 loads the model from `cfg_wdata[7:4]`. Model 0000b selects cluster and any other value selects flat. A format write leaves the logical ID unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0: logical ID register, 1: format register |
| cfg_wdata | input | 8 | Most significant byte of the addressed register |
| local_id | input | 8 | Physical ID of this controller |
| msg_valid | input | 1 | Message strobe |
| msg_shorthand | input | 2 | 00 none, 01 self, 10 all, 11 all but sender |
| msg_logical | input | 1 | Destination mode: 1 logical, 0 physical |
| msg_dest | input | 8 | Destination field |
| msg_src_id | input | 8 | Physical ID of the sender |
| acc_valid | output | 1 | Message accepted (one-cycle pulse) |
| acc_bcast | output | 1 | The accepted message was a broadcast |

## Verification
The bound checker watches every cycle for the following:
- the one-cycle relation between the strobe and the flags;
- the shorthand outcomes for sender equal to or different from the local ID;
- the all-ones physical broadcast;
- exact physical matches;
- refusal of a logical 00h;
- `acc_bcast` never being raised without `acc_valid`.

Several behaviours depend on the contents of the two stored registers, which only a write sequence can establish. These are the flat and cluster matches, the all-clusters nibble, the model decode and the reset values of the registers. The bench scenarios demonstrate these by programming the registers and probing with chosen addresses.

// File: rtl/ipi_filt_pkg.sv
package ipi_filt_pkg;

   typedef enum logic [1:0] {
      SH_NONE   = 2'b00,
      SH_SELF   = 2'b01,
      SH_ALL    = 2'b10,
      SH_OTHERS = 2'b11
   } shorthand_e;

   typedef enum logic {
      CFG_LOGID  = 1'b0,
      CFG_FORMAT = 1'b1
   } cfg_sel_e;

   typedef struct packed {
      logic hit;
      logic bcast;
   } match_t;

endpackage

// File: rtl/ipi_cfg_regs.sv
module ipi_cfg_regs
   import ipi_filt_pkg::*;
#(
   parameter int ID_W    = 8,
   parameter int MODEL_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  cfg_sel_e           cfg_sel,
   input  logic [ID_W-1:0]    cfg_wdata,
   output logic [ID_W-1:0]    log_id,
   output logic [MODEL_W-1:0] model
);

   generate
      if (MODEL_W > ID_W || MODEL_W < 1) begin : g_bad_model_w
         $error("ipi_cfg_regs: MODEL_W must be within 1..ID_W");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         log_id <= '0;
         model  <= '1;
      end else if (cfg_we) begin
         if (cfg_sel == CFG_LOGID) begin
            log_id <= cfg_wdata;
         end else begin
            model <= cfg_wdata[ID_W-1 -: MODEL_W];
         end
      end
   end

endmodule

// File: rtl/ipi_phys_match.sv
module ipi_phys_match
   import ipi_filt_pkg::*;
#(
   parameter int ID_W = 8
) (
   input  logic [ID_W-1:0] dest,
   input  logic [ID_W-1:0] local_id,
   output match_t          res
);

   logic all_ones;

   always_comb begin
      all_ones  = &dest;
      res.bcast = all_ones;
      res.hit   = all_ones || (dest == local_id);
   end

endmodule

// File: rtl/ipi_logic_match.sv
module ipi_logic_match
   import ipi_filt_pkg::*;
#(
   parameter int ID_W       = 8,
   parameter int MODEL_W    = 4,
   parameter bit CLUSTER_EN = 1'b1
) (
   input  logic [ID_W-1:0]    dest,
   input  logic [ID_W-1:0]    log_id,
   input  logic [MODEL_W-1:0] model,
   output logic               hit
);

   localparam int CL_W = ID_W / 2;

   logic flat_hit;

   generate
      if (ID_W < 2 || (ID_W % 2) != 0) begin : g_bad_id_w
         $error("ipi_logic_match: ID_W must be even and at least 2");
      end
   endgenerate

   assign flat_hit = |(dest & log_id);

   generate
      if (CLUSTER_EN) begin : g_cluster
         logic [CL_W-1:0] dst_cl, dst_mem, loc_cl, loc_mem;
         logic            cl_ok, mem_ok, is_cluster;

         always_comb begin
            dst_cl     = dest[ID_W-1 -: CL_W];
            dst_mem    = dest[CL_W-1:0];
            loc_cl     = log_id[ID_W-1 -: CL_W];
            loc_mem    = log_id[CL_W-1:0];
            cl_ok      = (&dst_cl) || (dst_cl == loc_cl);
            mem_ok     = |(dst_mem & loc_mem);
            is_cluster = (model == '0);
            hit        = is_cluster ? (cl_ok && mem_ok) : flat_hit;
         end
      end else begin : g_flat_only
         assign hit = flat_hit;
      end
   endgenerate

endmodule

// File: rtl/ipi_dest_filter.sv
module ipi_dest_filter
   import ipi_filt_pkg::*;
#(
   parameter int ID_W       = 8,
   parameter int MODEL_W    = 4,
   parameter bit CLUSTER_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic            cfg_sel,
   input  logic [ID_W-1:0] cfg_wdata,
   input  logic [ID_W-1:0] local_id,
   input  logic            msg_valid,
   input  logic [1:0]      msg_shorthand,
   input  logic            msg_logical,
   input  logic [ID_W-1:0] msg_dest,
   input  logic [ID_W-1:0] msg_src_id,
   output logic            acc_valid,
   output logic            acc_bcast
);

   logic [ID_W-1:0]    log_id;
   logic [MODEL_W-1:0] model;
   match_t             phys_res;
   logic               logic_hit;
   match_t             sel_res;
   shorthand_e         sh;
   logic               from_self;

   ipi_cfg_regs #(.ID_W(ID_W), .MODEL_W(MODEL_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel_e'(cfg_sel)),
      .cfg_wdata (cfg_wdata),
      .log_id    (log_id),
      .model     (model)
   );

   ipi_phys_match #(.ID_W(ID_W)) u_phys (
      .dest     (msg_dest),
      .local_id (local_id),
      .res      (phys_res)
   );

   ipi_logic_match #(.ID_W(ID_W), .MODEL_W(MODEL_W), .CLUSTER_EN(CLUSTER_EN)) u_logic (
      .dest   (msg_dest),
      .log_id (log_id),
      .model  (model),
      .hit    (logic_hit)
   );

   always_comb begin
      sh        = shorthand_e'(msg_shorthand);
      from_self = (msg_src_id == local_id);
      sel_res   = '0;
      unique case (sh)
         SH_NONE: begin
            if (msg_logical) begin
               sel_res.hit   = logic_hit;
               sel_res.bcast = 1'b0;
            end else begin
               sel_res = phys_res;
            end
         end
         SH_SELF: begin
            sel_res.hit   = from_self;
            sel_res.bcast = 1'b0;
         end
         SH_ALL: begin
            sel_res.hit   = 1'b1;
            sel_res.bcast = 1'b1;
         end
         SH_OTHERS: begin
            sel_res.hit   = !from_self;
            sel_res.bcast = !from_self;
         end
         default: sel_res = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_valid <= 1'b0;
         acc_bcast <= 1'b0;
      end else begin
         acc_valid <= msg_valid && sel_res.hit;
         acc_bcast <= msg_valid && sel_res.hit && sel_res.bcast;
      end
   end

endmodule

// File: rtl/ipi_dest_filter_chk.sv
module ipi_dest_filter_chk #(
   parameter int ID_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic [ID_W-1:0] local_id,
   input logic            msg_valid,
   input logic [1:0]      msg_shorthand,
   input logic            msg_logical,
   input logic [ID_W-1:0] msg_dest,
   input logic [ID_W-1:0] msg_src_id,
   input logic            acc_valid,
   input logic            acc_bcast
);

   AST_IDLE_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !msg_valid |=> (!acc_valid && !acc_bcast)); // R2
   AST_BCAST_NEEDS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      acc_bcast |-> acc_valid); // R2
   AST_SELF_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_shorthand == 2'b01 && msg_src_id == local_id) |=> (acc_valid && !acc_bcast)); // R3
   AST_SELF_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_shorthand == 2'b01 && msg_src_id != local_id) |=> !acc_valid); // R3
   AST_ALL_INCL: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_shorthand == 2'b10) |=> (acc_valid && acc_bcast)); // R4
   AST_ALL_EXCL_SENDER: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_shorthand == 2'b11 && msg_src_id == local_id) |=> !acc_valid); // R5
   AST_ALL_EXCL_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_shorthand == 2'b11 && msg_src_id != local_id) |=> (acc_valid && acc_bcast)); // R5
   AST_PHYS_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_shorthand == 2'b00 && !msg_logical && msg_dest == local_id && !(&msg_dest))
      |=> (acc_valid && !acc_bcast)); // R7
   AST_PHYS_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_shorthand == 2'b00 && !msg_logical && (&msg_dest)) |=> (acc_valid && acc_bcast)); // R8
   AST_LOGIC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_shorthand == 2'b00 && msg_logical && msg_dest == '0) |=> !acc_valid); // R11

endmodule

bind ipi_dest_filter ipi_dest_filter_chk #(.ID_W(ID_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .local_id      (local_id),
   .msg_valid     (msg_valid),
   .msg_shorthand (msg_shorthand),
   .msg_logical   (msg_logical),
   .msg_dest      (msg_dest),
   .msg_src_id    (msg_src_id),
   .acc_valid     (acc_valid),
   .acc_bcast     (acc_bcast)
);

// File: tb/tb_ipi_dest_filter.sv
`timescale 1ns/1ps
module tb_ipi_dest_filter;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic       cfg_sel = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] local_id = 8'h05;
   logic       msg_valid = 1'b0;
   logic [1:0] msg_shorthand = '0;
   logic       msg_logical = 1'b0;
   logic [7:0] msg_dest = '0;
   logic [7:0] msg_src_id = '0;
   logic       acc_valid, acc_bcast;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ipi_dest_filter dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .local_id(local_id), .msg_valid(msg_valid), .msg_shorthand(msg_shorthand),
      .msg_logical(msg_logical), .msg_dest(msg_dest), .msg_src_id(msg_src_id),
      .acc_valid(acc_valid), .acc_bcast(acc_bcast)
   );

   task automatic chk(input string req, input logic [1:0] got, input logic [1:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: {acc_valid,acc_bcast} actual=%b expected=%b", req, got, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [7:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // present one message for one cycle, then compare the registered result
   task automatic send(input string req, input logic [1:0] sh, input logic lg,
                       input logic [7:0] dst, input logic [7:0] src, input logic [1:0] exp);
      @(negedge clk);
      msg_valid = 1'b1; msg_shorthand = sh; msg_logical = lg; msg_dest = dst; msg_src_id = src;
      @(negedge clk);
      msg_valid = 1'b0;
      chk(req, {acc_valid, acc_bcast}, exp);
   endtask

   task automatic t_reset;
      chk("R1 reset outputs", {acc_valid, acc_bcast}, 2'b00);
      send("R1 logical id resets to zero", 2'b00, 1'b1, 8'hFF, 8'h09, 2'b00);
      wr(1'b0, 8'h21);
      send("R1 format resets to flat", 2'b00, 1'b1, 8'h01, 8'h09, 2'b10);
   endtask

   task automatic t_timing;
      @(negedge clk);
      msg_valid = 1'b0; msg_shorthand = 2'b10;
      @(negedge clk);
      chk("R2 no strobe no accept", {acc_valid, acc_bcast}, 2'b00);
      msg_valid = 1'b1;
      @(negedge clk);
      msg_valid = 1'b0;
      chk("R2 accept one cycle after strobe", {acc_valid, acc_bcast}, 2'b11);
      @(negedge clk);
      chk("R2 accept lasts one cycle", {acc_valid, acc_bcast}, 2'b00);
   endtask

   task automatic t_self;
      send("R3 self from local id", 2'b01, 1'b0, 8'h00, 8'h05, 2'b10);
      send("R3 self from other id", 2'b01, 1'b0, 8'h05, 8'h06, 2'b00);
   endtask

   task automatic t_all;
      send("R4 all incl, other sender", 2'b10, 1'b0, 8'h00, 8'h06, 2'b11);
      send("R4 all incl, self sender", 2'b10, 1'b0, 8'h00, 8'h05, 2'b11);
   endtask

   task automatic t_others;
      send("R5 all excl, self sender", 2'b11, 1'b0, 8'h00, 8'h05, 2'b00);
      send("R5 all excl, other sender", 2'b11, 1'b0, 8'h00, 8'h09, 2'b11);
   endtask

   task automatic t_ignore;
      send("R6 self ignores mismatching dest", 2'b01, 1'b0, 8'h77, 8'h05, 2'b10);
      send("R6 excl ignores matching dest", 2'b11, 1'b0, 8'h05, 8'h05, 2'b00);
      send("R6 all ignores logical 00h", 2'b10, 1'b1, 8'h00, 8'h05, 2'b11);
   endtask

   task automatic t_phys;
      send("R7 exact match", 2'b00, 1'b0, 8'h05, 8'h09, 2'b10);
      send("R7 mismatch", 2'b00, 1'b0, 8'h06, 8'h09, 2'b00);
      local_id = 8'hFE;
      send("R7 id FEh match", 2'b00, 1'b0, 8'hFE, 8'h09, 2'b10);
      local_id = 8'h00;
      send("R7 id 00h match", 2'b00, 1'b0, 8'h00, 8'h09, 2'b10);
      local_id = 8'h05;
   endtask

   task automatic t_phys_bc;
      send("R8 physical FFh broadcast", 2'b00, 1'b0, 8'hFF, 8'h09, 2'b11);
   endtask

   task automatic t_flat;
      send("R9 flat overlap 20h", 2'b00, 1'b1, 8'h20, 8'h09, 2'b10);
      send("R9 flat no overlap 40h", 2'b00, 1'b1, 8'h40, 8'h09, 2'b00);
      send("R9 flat overlap 81h", 2'b00, 1'b1, 8'h81, 8'h09, 2'b10);
      send("R11 flat 00h refused", 2'b00, 1'b1, 8'h00, 8'h09, 2'b00);
   endtask

   task automatic t_cluster;
      wr(1'b1, 8'h0F);
      wr(1'b0, 8'h32);
      send("R10 cluster exact", 2'b00, 1'b1, 8'h32, 8'h09, 2'b10);
      send("R10 cluster member overlap", 2'b00, 1'b1, 8'h33, 8'h09, 2'b10);
      send("R10 cluster member miss", 2'b00, 1'b1, 8'h31, 8'h09, 2'b00);
      send("R10 cluster other cluster", 2'b00, 1'b1, 8'h22, 8'h09, 2'b00);
      send("R10 cluster all clusters hit", 2'b00, 1'b1, 8'hF2, 8'h09, 2'b10);
      send("R10 cluster all clusters miss", 2'b00, 1'b1, 8'hF1, 8'h09, 2'b00);
      send("R11 cluster 00h refused", 2'b00, 1'b1, 8'h00, 8'h09, 2'b00);
   endtask

   task automatic t_model;
      wr(1'b1, 8'h50);
      send("R12 model 0101b is flat, id kept", 2'b00, 1'b1, 8'h02, 8'h09, 2'b10);
      wr(1'b1, 8'h00);
      send("R12 model 0000b is cluster", 2'b00, 1'b1, 8'h02, 8'h09, 2'b00);
      wr(1'b1, 8'hF0);
      send("R12 model 1111b is flat", 2'b00, 1'b1, 8'h02, 8'h09, 2'b10);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_timing();
      t_self();
      t_all();
      t_others();
      t_ignore();
      t_phys();
      t_phys_bc();
      t_flat();
      t_cluster();
      t_model();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule